// File: doc/BRIEF.md
# Translation Unit Control and Fault Capture Registers

This block holds the register-side control of a device address-translation unit. A simple word-addressed register port sets the operating mode, the first-level table size and the table base address, and it issues TLB flushes. The block holds the translation datapath in one of three modes: off, running, or held (translation stalled). The datapath reports fault events as a vector of eight fault classes, together with the faulting address.

When a fault arrives while translation is on, the block sets a sticky status bit for each reported class. It stores the address in one of four capture registers, chosen by the kind of fault. It forces the unit into the held state and raises an interrupt through a mask. Software finds the pending fault with the lowest index through a priority register and clears it with a clear write. It then resumes translation by writing the run code to the control register. A one-cycle invalidate pulse goes to the TLB on a flush command or on any new table base.

Register map (byte offsets, low two address bits ignored): 0x00 control, 0x04 config, 0x08 table base, 0x0C flush (write-only), 0x10 status (read-only), 0x14 clear (write-only), 0x18 page-fault address, 0x1C read-side fault address, 0x20 write-side fault address, 0x24 bus-error address, 0x28 interrupt mask, 0x2C top pending fault. All unlisted offsets read as zero.

Top module: `iotrans_ctl`

## Requirements
- R1: After reset the mode is off (control reads 0x0, `xlat_en`=0, `xlat_stall`=0). Status, config, table base, `irq` and `tlb_inv` are all zero, and the interrupt mask reads 0xFF.
- R2: A control write of 0x5 selects running (`xlat_en`=1, `xlat_stall`=0). A write of 0x7 selects held (`xlat_en`=1, `xlat_stall`=1). A write of 0x0 selects off. Any other value leaves the mode unchanged. The control register reads back the code of the current mode.
- R3: A fault on class k while the mode is not off sets status bit k in the next cycle and puts the unit in held. The class order is: bit 0 page fault, bit 1 read multi-hit, bit 2 write multi-hit, bit 3 bus error, bit 4 read security, bit 5 read access, bit 6 write security, bit 7 write access. A fault takes precedence over a control write in the same cycle.
- R4: Fault events that arrive while the mode is off change neither the status nor any address register.
- R5: The faulting address is captured into the register of its group. Bit 0 goes to offset 0x18. Bits 1, 4 and 5 go to 0x1C. Bits 2, 6 and 7 go to 0x20. Bit 3 goes to 0x24. The other address registers keep their values.
- R6: Status bits stay set until a write to the clear register. That write clears exactly the bits that are one in the written data. A fault on a bit in the same cycle as its clear leaves that bit set.
- R7: `irq` is high while any status bit is set whose mask bit (mask register bit k) is one.
- R8: Held persists after the status is cleared. Only a control write leaves it.
- R9: A flush write with data bit 0 set, or any table-base write, makes `tlb_inv` high for exactly the one cycle after the write. A flush write with bit 0 clear gives no pulse.
- R10: Config bit 5 selects the small (4 KB) first-level table and drives `small_l1`. All other config bits read as zero. The table base reads back as written and drives `tbase`.
- R11: Writes to read-only registers (status, address registers, top pending) are ignored. Reads of unmapped offsets return zero.
- R12: The top-pending register reads bit 3 = any status bit set, and bits 2:0 = index of the lowest set status bit. It reads zero when no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW (6) | Register byte offset |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data (combinational from reg_addr) |
| fault_vld | input | 8 | One bit per fault class from the translation datapath |
| fault_addr | input | DW (32) | Address that caused the reported faults |
| xlat_en | output | 1 | Translation enabled (running or held) |
| xlat_stall | output | 1 | Translation stalled (held) |
| irq | output | 1 | Interrupt: any unmasked status bit set |
| tlb_inv | output | 1 | One-cycle invalidate-all pulse to the TLB |
| small_l1 | output | 1 | Small first-level table selected |
| tbase | output | DW (32) | First-level table base address |

## Verification
Two pairs of events can fall in the same clock cycle, and the bench drives each pair in one cycle. In the first pair, a fault lands on a status bit while software clears that same bit. The bench expects the bit to stay set. A clear of a different bit alongside a fault is still expected to take effect. In the second pair, a fault coincides with a control write of the run code. The bench expects the stall output to remain high, the control register to read the held code, and the write-side address register to hold the new address.

// File: rtl/iotrans_pkg.sv
package iotrans_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    localparam int NUM_FAULT = 8;
    localparam int NUM_AGRP  = 4;
    localparam int IDX_W     = $clog2(NUM_FAULT);

    localparam logic [7:0] CODE_OFF  = 8'h00;
    localparam logic [7:0] CODE_RUN  = 8'h05;
    localparam logic [7:0] CODE_HOLD = 8'h07;

    localparam int CFG_SMALL_BIT = 5;

    // word indices of the register map
    localparam logic [3:0] RI_CTRL  = 4'd0;
    localparam logic [3:0] RI_CFG   = 4'd1;
    localparam logic [3:0] RI_TBASE = 4'd2;
    localparam logic [3:0] RI_FLUSH = 4'd3;
    localparam logic [3:0] RI_STAT  = 4'd4;
    localparam logic [3:0] RI_CLR   = 4'd5;
    localparam logic [3:0] RI_APGF  = 4'd6;
    localparam logic [3:0] RI_ARD   = 4'd7;
    localparam logic [3:0] RI_AWR   = 4'd8;
    localparam logic [3:0] RI_ABUS  = 4'd9;
    localparam logic [3:0] RI_MASK  = 4'd10;
    localparam logic [3:0] RI_TOP   = 4'd11;

    // address capture groups
    localparam int AG_PAGE  = 0;
    localparam int AG_READ  = 1;
    localparam int AG_WRITE = 2;
    localparam int AG_BUS   = 3;

    function automatic logic [NUM_FAULT-1:0] grp_mask(input int g);
        case (g)
            AG_PAGE:  grp_mask = 8'b0000_0001;
            AG_READ:  grp_mask = 8'b0011_0010;
            AG_WRITE: grp_mask = 8'b1100_0100;
            default:  grp_mask = 8'b0000_1000;
        endcase
    endfunction

endpackage

// File: rtl/iotrans_mode_fsm.sv
module iotrans_mode_fsm
    import iotrans_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [DW-1:0] ctrl_code,
    input  logic          flt_any,
    output mode_e         mode,
    output logic          xlat_en,
    output logic          xlat_stall,
    output logic [DW-1:0] ctrl_rd
);

    mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (flt_any) begin
            state_d = MODE_HOLD;
        end else if (ctrl_we) begin
            if (ctrl_code == DW'(CODE_RUN))       state_d = MODE_RUN;
            else if (ctrl_code == DW'(CODE_HOLD)) state_d = MODE_HOLD;
            else if (ctrl_code == DW'(CODE_OFF))  state_d = MODE_OFF;
        end
    end

    // outputs
    always_comb begin
        xlat_en    = 1'b0;
        xlat_stall = 1'b0;
        ctrl_rd    = '0;
        unique case (state_q)
            MODE_OFF: begin
                ctrl_rd = DW'(CODE_OFF);
            end
            MODE_RUN: begin
                xlat_en = 1'b1;
                ctrl_rd = DW'(CODE_RUN);
            end
            MODE_HOLD: begin
                xlat_en    = 1'b1;
                xlat_stall = 1'b1;
                ctrl_rd    = DW'(CODE_HOLD);
            end
            default: ;
        endcase
    end

    assign mode = state_q;

    // R3: a fault always lands the unit in held
    a_r3_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flt_any |=> state_q == MODE_HOLD);

    // R8: held is left only through a control write
    a_r8_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HOLD && !ctrl_we) |=> state_q == MODE_HOLD);

    // R2: an unknown code leaves the mode alone
    a_r2_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !flt_any && ctrl_code != DW'(CODE_RUN) &&
         ctrl_code != DW'(CODE_HOLD) && ctrl_code != DW'(CODE_OFF))
        |=> state_q == $past(state_q));

endmodule

// File: rtl/iotrans_fault_log.sv
module iotrans_fault_log
    import iotrans_pkg::*;
#(
    parameter int DW = 32,
    parameter int NF = NUM_FAULT,
    parameter int NG = NUM_AGRP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NF-1:0]          flt_vld,
    input  logic [DW-1:0]          flt_addr,
    input  logic                   clr_we,
    input  logic                   mask_we,
    input  logic [DW-1:0]          wdata,
    output logic [NF-1:0]          status,
    output logic [NF-1:0]          mask,
    output logic [NG-1:0][DW-1:0]  addr_q,
    output logic                   top_vld,
    output logic [IDX_W-1:0]       top_idx,
    output logic                   irq
);

    logic [NF-1:0] clr_bits;
    logic [NF-1:0] status_d;

    assign clr_bits = clr_we ? wdata[NF-1:0] : '0;
    // a fault on a bit wins over its clear
    assign status_d = (status & ~clr_bits) | flt_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= wdata[NF-1:0];
    end

    // one address register per fault group
    for (genvar g = 0; g < NG; g++) begin : g_cap
        logic hit;
        assign hit = |(flt_vld & grp_mask(g));
        always_ff @(posedge clk) begin
            if (!rst_n)   addr_q[g] <= '0;
            else if (hit) addr_q[g] <= flt_addr;
        end
    end

    // lowest set index has priority
    always_comb begin
        top_idx = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (status[i]) top_idx = IDX_W'(i);
        end
    end
    assign top_vld = |status;

    assign irq = |(status & mask);

    // R6: without a clear no status bit drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (status & $past(status)) == $past(status));

    // R6: a fault bit is set afterwards even under a clear
    a_r6_fault_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_vld) |=> (status & $past(flt_vld)) == $past(flt_vld));

    // R5: page fault address lands in its own register
    a_r5_page_capture: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld[0] |=> addr_q[AG_PAGE] == $past(flt_addr));

    // R12: the reported index is a set bit
    a_r12_top_set: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld |-> status[top_idx]);

endmodule

// File: rtl/iotrans_cfg_regs.sv
module iotrans_cfg_regs
    import iotrans_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          tbase_we,
    input  logic          flush_we,
    input  logic [DW-1:0] wdata,
    output logic          small_l1,
    output logic [DW-1:0] tbase,
    output logic          tlb_inv
);

    logic inv_req;
    assign inv_req = tbase_we || (flush_we && wdata[0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            small_l1 <= 1'b0;
            tbase    <= '0;
            tlb_inv  <= 1'b0;
        end else begin
            if (cfg_we)   small_l1 <= wdata[CFG_SMALL_BIT];
            if (tbase_we) tbase    <= wdata;
            tlb_inv <= inv_req;
        end
    end

    // R9: every pulse has a cause one cycle earlier
    a_r9_inv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inv |-> $past(tbase_we || (flush_we && wdata[0])));

    // R9: a flush with bit 0 low alone gives no pulse
    a_r9_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_we && !wdata[0] && !tbase_we) |=> !tlb_inv);

endmodule

// File: rtl/iotrans_ctl.sv
module iotrans_ctl
    import iotrans_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RAW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [RAW-1:0]       reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [NUM_FAULT-1:0] fault_vld,
    input  logic [DW-1:0]        fault_addr,
    output logic                 xlat_en,
    output logic                 xlat_stall,
    output logic                 irq,
    output logic                 tlb_inv,
    output logic                 small_l1,
    output logic [DW-1:0]        tbase
);

    localparam int IW = RAW - 2;

    logic [IW-1:0] widx;
    assign widx = reg_addr[RAW-1:2];

    function automatic logic hit(input logic [IW-1:0] a, input logic [3:0] r);
        hit = (a == IW'(r));
    endfunction

    mode_e                          mode;
    logic [DW-1:0]                  ctrl_rd;
    logic [NUM_FAULT-1:0]           flt_g;
    logic [NUM_FAULT-1:0]           status, mask;
    logic [NUM_AGRP-1:0][DW-1:0]    addr_q;
    logic                           top_vld;
    logic [IDX_W-1:0]               top_idx;

    // faults count only while translation is on
    assign flt_g = (mode != MODE_OFF) ? fault_vld : '0;

    iotrans_mode_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (reg_we && hit(widx, RI_CTRL)),
        .ctrl_code  (reg_wdata),
        .flt_any    (|flt_g),
        .mode       (mode),
        .xlat_en    (xlat_en),
        .xlat_stall (xlat_stall),
        .ctrl_rd    (ctrl_rd)
    );

    iotrans_fault_log #(.DW(DW)) u_flog (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_vld  (flt_g),
        .flt_addr (fault_addr),
        .clr_we   (reg_we && hit(widx, RI_CLR)),
        .mask_we  (reg_we && hit(widx, RI_MASK)),
        .wdata    (reg_wdata),
        .status   (status),
        .mask     (mask),
        .addr_q   (addr_q),
        .top_vld  (top_vld),
        .top_idx  (top_idx),
        .irq      (irq)
    );

    iotrans_cfg_regs #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (reg_we && hit(widx, RI_CFG)),
        .tbase_we (reg_we && hit(widx, RI_TBASE)),
        .flush_we (reg_we && hit(widx, RI_FLUSH)),
        .wdata    (reg_wdata),
        .small_l1 (small_l1),
        .tbase    (tbase),
        .tlb_inv  (tlb_inv)
    );

    always_comb begin
        reg_rdata = '0;
        if      (hit(widx, RI_CTRL))  reg_rdata = ctrl_rd;
        else if (hit(widx, RI_CFG))   reg_rdata[CFG_SMALL_BIT] = small_l1;
        else if (hit(widx, RI_TBASE)) reg_rdata = tbase;
        else if (hit(widx, RI_STAT))  reg_rdata[NUM_FAULT-1:0] = status;
        else if (hit(widx, RI_APGF))  reg_rdata = addr_q[AG_PAGE];
        else if (hit(widx, RI_ARD))   reg_rdata = addr_q[AG_READ];
        else if (hit(widx, RI_AWR))   reg_rdata = addr_q[AG_WRITE];
        else if (hit(widx, RI_ABUS))  reg_rdata = addr_q[AG_BUS];
        else if (hit(widx, RI_MASK))  reg_rdata[NUM_FAULT-1:0] = mask;
        else if (hit(widx, RI_TOP))   reg_rdata[IDX_W:0] = {top_vld, top_idx};
    end

    // R4: while off and unwritten, status holds
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !reg_we) |=> status == $past(status));

    // R7: interrupt implies some unmasked pending class
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|status));

endmodule

// File: tb/test_iotrans_ctl.sv
`timescale 1ns/1ps
module test_iotrans_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  fault_vld = '0;
    logic [31:0] fault_addr = '0;
    logic        xlat_en, xlat_stall, irq, tlb_inv, small_l1;
    logic [31:0] tbase;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iotrans_ctl i_iotrans_ctl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_vld(fault_vld),
        .fault_addr(fault_addr), .xlat_en(xlat_en), .xlat_stall(xlat_stall),
        .irq(irq), .tlb_inv(tlb_inv), .small_l1(small_l1), .tbase(tbase)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string rq, input logic [5:0] a, input logic [31:0] e);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(rq, reg_rdata, e);
    endtask

    task automatic flt(input logic [7:0] v, input logic [31:0] a);
        @(negedge clk);
        fault_vld = v; fault_addr = a;
        @(negedge clk);
        fault_vld = '0;
    endtask

    // {op, req, offset, a, b}; op 0 write(a), 1 read expect b, 2 fault(a=classes, b=addr)
    localparam int NV = 40;
    localparam logic [75:0] VEC [NV] = '{
        {2'd1, 4'd1,  6'h00, 32'h0, 32'h0},          // R1 control off
        {2'd1, 4'd1,  6'h28, 32'h0, 32'hFF},         // R1 mask reset
        {2'd1, 4'd1,  6'h10, 32'h0, 32'h0},          // R1 status reset
        {2'd0, 4'd2,  6'h00, 32'h5, 32'h0},          // R2 run
        {2'd1, 4'd2,  6'h00, 32'h0, 32'h5},
        {2'd0, 4'd2,  6'h00, 32'h3, 32'h0},          // R2 bad code
        {2'd1, 4'd2,  6'h00, 32'h0, 32'h5},
        {2'd2, 4'd3,  6'h00, 32'h20, 32'h10000040},  // R3 read access fault
        {2'd1, 4'd3,  6'h00, 32'h0, 32'h7},
        {2'd1, 4'd3,  6'h10, 32'h0, 32'h20},
        {2'd1, 4'd5,  6'h1C, 32'h0, 32'h10000040},   // R5 read group
        {2'd1, 4'd5,  6'h18, 32'h0, 32'h0},
        {2'd2, 4'd3,  6'h00, 32'h88, 32'hDEAD0000},  // R3 bus error + write access
        {2'd1, 4'd3,  6'h10, 32'h0, 32'hA8},
        {2'd1, 4'd5,  6'h20, 32'h0, 32'hDEAD0000},
        {2'd1, 4'd5,  6'h24, 32'h0, 32'hDEAD0000},
        {2'd1, 4'd5,  6'h1C, 32'h0, 32'h10000040},
        {2'd1, 4'd12, 6'h2C, 32'h0, 32'hB},          // R12 lowest = 3
        {2'd0, 4'd6,  6'h14, 32'h08, 32'h0},         // R6 clear bit 3
        {2'd1, 4'd6,  6'h10, 32'h0, 32'hA0},
        {2'd1, 4'd12, 6'h2C, 32'h0, 32'hD},          // R12 lowest = 5
        {2'd0, 4'd11, 6'h10, 32'hFF, 32'h0},         // R11 read-only
        {2'd1, 4'd11, 6'h10, 32'h0, 32'hA0},
        {2'd0, 4'd11, 6'h1C, 32'h0, 32'h0},
        {2'd1, 4'd11, 6'h1C, 32'h0, 32'h10000040},
        {2'd1, 4'd11, 6'h30, 32'h0, 32'h0},
        {2'd1, 4'd11, 6'h0C, 32'h0, 32'h0},
        {2'd0, 4'd6,  6'h14, 32'hA0, 32'h0},
        {2'd1, 4'd6,  6'h10, 32'h0, 32'h0},
        {2'd1, 4'd12, 6'h2C, 32'h0, 32'h0},
        {2'd1, 4'd8,  6'h00, 32'h0, 32'h7},          // R8 still held
        {2'd0, 4'd8,  6'h00, 32'h5, 32'h0},
        {2'd1, 4'd8,  6'h00, 32'h0, 32'h5},
        {2'd0, 4'd4,  6'h00, 32'h0, 32'h0},          // R4 off
        {2'd2, 4'd4,  6'h00, 32'h01, 32'h55},
        {2'd1, 4'd4,  6'h10, 32'h0, 32'h0},
        {2'd1, 4'd4,  6'h18, 32'h0, 32'h0},
        {2'd0, 4'd10, 6'h04, 32'hFFFFFFFF, 32'h0},   // R10 config
        {2'd1, 4'd10, 6'h04, 32'h0, 32'h20},
        {2'd1, 4'd10, 6'h00, 32'h0, 32'h0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 port state after reset
        chk("R1 en", {31'b0, xlat_en}, 32'h0);
        chk("R1 stall", {31'b0, xlat_stall}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 inv", {31'b0, tlb_inv}, 32'h0);
        chk("R1 tbase", tbase, 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [5:0]  off;
            logic [31:0] va, vb;
            {op, rq, off, va, vb} = VEC[k];
            case (op)
                2'd0: wr(off, va);
                2'd1: rd($sformatf("R%0d vec%0d", rq, k), off, vb);
                default: flt(va[7:0], vb);
            endcase
        end

        // R2 port view of each mode
        wr(6'h00, 32'h7);
        chk("R2 hold en", {31'b0, xlat_en}, 32'h1);
        chk("R2 hold stall", {31'b0, xlat_stall}, 32'h1);
        wr(6'h00, 32'h5);
        chk("R2 run stall", {31'b0, xlat_stall}, 32'h0);
        chk("R2 run en", {31'b0, xlat_en}, 32'h1);
        wr(6'h00, 32'h0);
        chk("R2 off en", {31'b0, xlat_en}, 32'h0);

        // R9 invalidate pulses
        wr(6'h0C, 32'h1);
        chk("R9 flush pulse", {31'b0, tlb_inv}, 32'h1);
        @(negedge clk);
        chk("R9 pulse width", {31'b0, tlb_inv}, 32'h0);
        wr(6'h0C, 32'h2);
        chk("R9 flush bit0 low", {31'b0, tlb_inv}, 32'h0);
        wr(6'h08, 32'h00ABC000);
        chk("R9 tbase pulse", {31'b0, tlb_inv}, 32'h1);
        chk("R10 tbase port", tbase, 32'h00ABC000);

        // R10 table size select
        chk("R10 small set", {31'b0, small_l1}, 32'h1);
        wr(6'h04, 32'h0);
        chk("R10 small clear", {31'b0, small_l1}, 32'h0);

        // R7 interrupt and mask
        wr(6'h00, 32'h5);
        flt(8'h04, 32'h0000A000);
        chk("R7 irq raised", {31'b0, irq}, 32'h1);
        wr(6'h28, 32'hFB);
        chk("R7 masked", {31'b0, irq}, 32'h0);
        wr(6'h28, 32'hFF);
        chk("R7 unmasked", {31'b0, irq}, 32'h1);
        wr(6'h14, 32'h04);
        chk("R7 cleared", {31'b0, irq}, 32'h0);

        // R6 same-cycle fault and clear
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h14; reg_wdata = 32'h02;
        fault_vld = 8'h02; fault_addr = 32'h0000B000;
        @(negedge clk);
        reg_we = 1'b0; fault_vld = '0;
        rd("R6 fault beats clear", 6'h10, 32'h02);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h14; reg_wdata = 32'h02;
        fault_vld = 8'h01; fault_addr = 32'h0000C000;
        @(negedge clk);
        reg_we = 1'b0; fault_vld = '0;
        rd("R6 other bit cleared", 6'h10, 32'h01);
        wr(6'h14, 32'hFF);

        // R3 same-cycle fault and resume write
        wr(6'h00, 32'h5);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h5;
        fault_vld = 8'h40; fault_addr = 32'h7777_0000;
        @(negedge clk);
        reg_we = 1'b0; fault_vld = '0;
        chk("R3 fault beats resume", {31'b0, xlat_stall}, 32'h1);
        rd("R3 held code", 6'h00, 32'h7);
        rd("R5 write group", 6'h20, 32'h7777_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule